// File: doc/BRIEF.md
# Fully Associative Page Translation Cache

This block holds a small set of recent virtual-to-physical page translations. A lookup presents a full virtual address. The virtual page number is compared against every stored tag in the same cycle. One clock later the block reports a hit or a miss. On a hit it returns the physical address, which is the stored physical frame number placed above the 12-bit page offset carried over unchanged from the request. It also returns the entry's protection and dirty attributes.

After a miss, an external page walker fetches the translation and writes it back through the refill port. The block picks the slot for the refill. If the page is already cached, its own entry is reused. Otherwise the lowest free slot is taken. When every slot is valid, a round-robin victim pointer chooses the slot.

Three maintenance commands remove translations. One drops a single page. One is used on a context switch and drops every entry not marked global. One clears the whole cache.

Top module: `xlc_cache`

## Requirements
- R1: After reset no response is signalled (`resp_valid_o`, `resp_hit_o`, `resp_miss_o` low) and every entry is invalid, so the first lookups miss.
- R2: A lookup compares bits [31:12] of `lookup_va_i` with all valid entries at once. In the following cycle `resp_valid_o` is high and exactly one of `resp_hit_o` / `resp_miss_o` is high. With no lookup, all three are low.
- R3: On a hit, `resp_pa_o` is {stored frame number, `lookup_va_i[11:0]`}, and `resp_prot_o` and `resp_dirty_o` are the stored attributes. On a miss, these three outputs are zero.
- R4: A refill whose page number matches a valid entry overwrites that entry. Otherwise it goes to the lowest-index invalid entry. The refilled translation hits from the next lookup on.
- R5: When all entries are valid and the refill matches none of them, the entry at the round-robin pointer is replaced. The pointer resets to 0, advances by one per such replacement (wrapping at 16), and does not move otherwise.
- R6: A refill in the same cycle as a lookup wins. The lookup is dropped, and `resp_valid_o` stays low in the next cycle.
- R7: A single-page invalidate clears only the entry whose page number equals `inv_vpn_i`. All other entries keep hitting.
- R8: A context flush clears every entry whose global flag is 0 and keeps every global entry.
- R9: A full flush clears every entry, global ones included, in one cycle.
- R10: Only one operation acts per cycle, in this priority: full flush, context flush, page invalidate, refill, lookup. Any maintenance command blocks a refill or lookup in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | Lookup request |
| lookup_va_i | input | 32 | Virtual address to translate |
| refill_valid_i | input | 1 | Install a translation |
| refill_vpn_i | input | 20 | Virtual page number of the refill |
| refill_pfn_i | input | 24 | Physical frame number of the refill |
| refill_prot_i | input | 3 | Protection attribute of the refill |
| refill_dirty_i | input | 1 | Dirty attribute of the refill |
| refill_global_i | input | 1 | Global flag of the refill |
| inv_page_i | input | 1 | Invalidate one page |
| inv_vpn_i | input | 20 | Page number to invalidate |
| flush_ctx_i | input | 1 | Clear all non-global entries |
| flush_all_i | input | 1 | Clear all entries |
| resp_valid_o | output | 1 | Lookup result present |
| resp_hit_o | output | 1 | Lookup hit |
| resp_miss_o | output | 1 | Lookup miss |
| resp_pa_o | output | 36 | Translated physical address |
| resp_prot_o | output | 3 | Protection of the hit entry |
| resp_dirty_o | output | 1 | Dirty flag of the hit entry |

## Verification
The bench fills all sixteen slots and sweeps every cached page with varied offsets. A design that mangled the offset splice or muxed the wrong entry's attributes would return wrong addresses. It then overfills the cache and invalidates a slot in the middle. A victim choice that ignores free slots, or that moves the round-robin pointer on free-slot refills, would evict the wrong page, and the sweep would show it. A repeated refill of a cached page checks that the page is not stored twice, since a duplicate would OR two frame numbers together. Collisions between a refill and a lookup, and between a flush and a refill, check the priority order. A context flush must leave only the global pages, and a full flush must leave nothing.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
  localparam int unsigned OFF_W  = 12;
  localparam int unsigned VPN_W  = 20;
  localparam int unsigned VA_W   = VPN_W + OFF_W;
  localparam int unsigned PFN_W  = 24;
  localparam int unsigned PA_W   = PFN_W + OFF_W;
  localparam int unsigned PROT_W = 3;

  typedef struct packed {
    logic [PFN_W-1:0]  pfn;
    logic [PROT_W-1:0] prot;
    logic              dirty;
  } xlc_data_t;

  typedef struct packed {
    logic             vld;
    logic             glb;
    logic [VPN_W-1:0] vpn;
    xlc_data_t        data;
  } xlc_entry_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_LOOKUP, OP_REFILL, OP_INV, OP_CTX, OP_ALL
  } xlc_op_e;
endpackage

// File: rtl/xlc_match.sv
module xlc_match
  import xlc_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0]            vld_i,
  input  logic [N-1:0][VPN_W-1:0] tag_i,
  input  xlc_data_t [N-1:0]       data_i,
  input  logic [VPN_W-1:0]        vpn_i,
  output logic [N-1:0]            hit_o,
  output xlc_data_t               data_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = vld_i[g] && (tag_i[g] == vpn_i);
  end

  // one-hot AND-OR mux; at most one entry matches a given page
  always_comb begin
    data_o = '0;
    for (int i = 0; i < N; i++)
      if (hit_o[i]) data_o = data_o | data_i[i];
  end
endmodule

// File: rtl/xlc_victim.sv
module xlc_victim #(
  parameter int unsigned N  = 16,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  vld_i,
  input  logic [N-1:0]  match_i,
  input  logic          fire_i,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] rr_q, free_idx, match_idx;
  logic          any_free, any_match;

  always_comb begin
    any_free  = 1'b0;
    free_idx  = '0;
    any_match = 1'b0;
    match_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_i[i]) begin
        any_free = 1'b1;
        free_idx = IW'(i);
      end
      if (match_i[i]) begin
        any_match = 1'b1;
        match_idx = IW'(i);
      end
    end
  end

  always_comb begin
    if (any_match)     idx_o = match_idx;
    else if (any_free) idx_o = free_idx;
    else               idx_o = rr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (fire_i && !any_match && !any_free)
      rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/xlc_cache.sv
module xlc_cache
  import xlc_pkg::*;
#(
  parameter int unsigned ENTRIES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_valid_i,
  input  logic [VA_W-1:0]   lookup_va_i,
  input  logic              refill_valid_i,
  input  logic [VPN_W-1:0]  refill_vpn_i,
  input  logic [PFN_W-1:0]  refill_pfn_i,
  input  logic [PROT_W-1:0] refill_prot_i,
  input  logic              refill_dirty_i,
  input  logic              refill_global_i,
  input  logic              inv_page_i,
  input  logic [VPN_W-1:0]  inv_vpn_i,
  input  logic              flush_ctx_i,
  input  logic              flush_all_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic              resp_miss_o,
  output logic [PA_W-1:0]   resp_pa_o,
  output logic [PROT_W-1:0] resp_prot_o,
  output logic              resp_dirty_o
);
  localparam int unsigned IW = $clog2(ENTRIES);

  xlc_entry_t [ENTRIES-1:0]          ents_q;
  logic [ENTRIES-1:0]                vld_vec;
  logic [ENTRIES-1:0][VPN_W-1:0]     tag_vec;
  xlc_data_t [ENTRIES-1:0]           data_vec;
  logic [ENTRIES-1:0]                hit_vec;
  xlc_data_t                         sel_data;
  logic [VPN_W-1:0]                  cmp_vpn;
  logic [IW-1:0]                     victim;
  xlc_op_e                           op;

  logic              rv_q, hit_q;
  logic [PA_W-1:0]   pa_q;
  logic [PROT_W-1:0] prot_q;
  logic              dirty_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_unpack
    assign vld_vec[g]  = ents_q[g].vld;
    assign tag_vec[g]  = ents_q[g].vpn;
    assign data_vec[g] = ents_q[g].data;
  end

  always_comb begin
    if (flush_all_i)         op = OP_ALL;
    else if (flush_ctx_i)    op = OP_CTX;
    else if (inv_page_i)     op = OP_INV;
    else if (refill_valid_i) op = OP_REFILL;
    else if (lookup_valid_i) op = OP_LOOKUP;
    else                     op = OP_NONE;
  end

  // one comparator array shared by lookup, refill and invalidate
  always_comb begin
    unique case (op)
      OP_REFILL: cmp_vpn = refill_vpn_i;
      OP_INV:    cmp_vpn = inv_vpn_i;
      default:   cmp_vpn = lookup_va_i[VA_W-1:OFF_W];
    endcase
  end

  xlc_match #(.N(ENTRIES)) u_match (
    .vld_i  (vld_vec),
    .tag_i  (tag_vec),
    .data_i (data_vec),
    .vpn_i  (cmp_vpn),
    .hit_o  (hit_vec),
    .data_o (sel_data)
  );

  xlc_victim #(.N(ENTRIES)) u_victim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (vld_vec),
    .match_i (hit_vec),
    .fire_i  (op == OP_REFILL),
    .idx_o   (victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ents_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        unique case (op)
          OP_ALL: ents_q[i].vld <= 1'b0;
          OP_CTX: if (!ents_q[i].glb) ents_q[i].vld <= 1'b0;
          OP_INV: if (hit_vec[i]) ents_q[i].vld <= 1'b0;
          OP_REFILL:
            if (IW'(i) == victim) begin
              ents_q[i].vld        <= 1'b1;
              ents_q[i].glb        <= refill_global_i;
              ents_q[i].vpn        <= refill_vpn_i;
              ents_q[i].data.pfn   <= refill_pfn_i;
              ents_q[i].data.prot  <= refill_prot_i;
              ents_q[i].data.dirty <= refill_dirty_i;
            end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rv_q    <= 1'b0;
      hit_q   <= 1'b0;
      pa_q    <= '0;
      prot_q  <= '0;
      dirty_q <= 1'b0;
    end else begin
      rv_q  <= (op == OP_LOOKUP);
      hit_q <= (op == OP_LOOKUP) && (|hit_vec);
      if ((op == OP_LOOKUP) && (|hit_vec)) begin
        pa_q    <= {sel_data.pfn, lookup_va_i[OFF_W-1:0]};
        prot_q  <= sel_data.prot;
        dirty_q <= sel_data.dirty;
      end else begin
        pa_q    <= '0;
        prot_q  <= '0;
        dirty_q <= 1'b0;
      end
    end
  end

  assign resp_valid_o = rv_q;
  assign resp_hit_o   = hit_q;
  assign resp_miss_o  = rv_q & ~hit_q;
  assign resp_pa_o    = pa_q;
  assign resp_prot_o  = prot_q;
  assign resp_dirty_o = dirty_q;
endmodule

// File: rtl/xlc_checker.sv
module xlc_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        lookup_valid_i,
  input logic [11:0] lookup_off_i,
  input logic        refill_valid_i,
  input logic        inv_page_i,
  input logic        flush_ctx_i,
  input logic        flush_all_i,
  input logic        resp_valid_o,
  input logic        resp_hit_o,
  input logic        resp_miss_o,
  input logic [11:0] resp_off_o
);
  assert_one_outcome_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $onehot({resp_hit_o, resp_miss_o}));

  assert_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_valid_o |-> !resp_hit_o && !resp_miss_o);

  assert_lookup_answers_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_valid_i && !refill_valid_i && !inv_page_i && !flush_ctx_i && !flush_all_i)
      |=> resp_valid_o);

  assert_offset_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_hit_o |-> resp_off_o == $past(lookup_off_i));

  assert_refill_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_valid_i |=> !resp_valid_o);

  assert_maint_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_page_i || flush_ctx_i || flush_all_i) |=> !resp_valid_o);

  assert_flush_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_hit_o |-> !$past(flush_all_i, 2));
endmodule

bind xlc_cache xlc_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lookup_valid_i (lookup_valid_i),
  .lookup_off_i   (lookup_va_i[11:0]),
  .refill_valid_i (refill_valid_i),
  .inv_page_i     (inv_page_i),
  .flush_ctx_i    (flush_ctx_i),
  .flush_all_i    (flush_all_i),
  .resp_valid_o   (resp_valid_o),
  .resp_hit_o     (resp_hit_o),
  .resp_miss_o    (resp_miss_o),
  .resp_off_o     (resp_pa_o[11:0])
);

// File: tb/xlc_cache_test.sv
module xlc_cache_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk = 1'b0;
  logic [31:0] lva = '0;
  logic        rf = 1'b0;
  logic [19:0] rvpn = '0;
  logic [23:0] rpfn = '0;
  logic [2:0]  rprot = '0;
  logic        rdirty = 1'b0, rglb = 1'b0;
  logic        inv = 1'b0;
  logic [19:0] ivpn = '0;
  logic        fctx = 1'b0, fall = 1'b0;
  logic        r_valid, r_hit, r_miss, r_dirty;
  logic [35:0] r_pa;
  logic [2:0]  r_prot;

  int tests = 0, fails = 0;
  bit done = 0;

  // requirement model
  bit          m_vld [N];
  bit          m_glb [N];
  logic [19:0] m_vpn [N];
  logic [23:0] m_pfn [N];
  logic [2:0]  m_prot[N];
  bit          m_dirty[N];
  int          m_rr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlc_cache uut (
    .clk_i(clk), .rst_ni(rst_n),
    .lookup_valid_i(lk), .lookup_va_i(lva),
    .refill_valid_i(rf), .refill_vpn_i(rvpn), .refill_pfn_i(rpfn),
    .refill_prot_i(rprot), .refill_dirty_i(rdirty), .refill_global_i(rglb),
    .inv_page_i(inv), .inv_vpn_i(ivpn),
    .flush_ctx_i(fctx), .flush_all_i(fall),
    .resp_valid_o(r_valid), .resp_hit_o(r_hit), .resp_miss_o(r_miss),
    .resp_pa_o(r_pa), .resp_prot_o(r_prot), .resp_dirty_o(r_dirty)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int m_find(input logic [19:0] vpn);
    for (int i = 0; i < N; i++) if (m_vld[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  // one cycle with any mix of commands; model follows R10 priority
  task automatic cycle(input string req, input bit l, input logic [31:0] va,
                       input bit r, input logic [19:0] vpn, input logic [23:0] pfn,
                       input logic [2:0] prot, input bit d, input bit g,
                       input bit iv, input logic [19:0] ivp, input bit fc, input bit fa);
    int idx;
    bit exp_v, exp_h;
    logic [35:0] exp_pa;
    logic [2:0]  exp_pr;
    bit exp_d;
    @(negedge clk);
    lk = l; lva = va; rf = r; rvpn = vpn; rpfn = pfn; rprot = prot; rdirty = d; rglb = g;
    inv = iv; ivpn = ivp; fctx = fc; fall = fa;
    exp_v = l && !r && !iv && !fc && !fa;
    idx = m_find(va[31:12]);
    exp_h = exp_v && idx >= 0;
    exp_pa = exp_h ? {m_pfn[idx], va[11:0]} : 36'h0;
    exp_pr = exp_h ? m_prot[idx] : 3'h0;
    exp_d  = exp_h ? m_dirty[idx] : 1'b0;
    if (fa) begin
      for (int i = 0; i < N; i++) m_vld[i] = 0;
    end else if (fc) begin
      for (int i = 0; i < N; i++) if (!m_glb[i]) m_vld[i] = 0;
    end else if (iv) begin
      idx = m_find(ivp);
      if (idx >= 0) m_vld[idx] = 0;
    end else if (r) begin
      idx = m_find(vpn);
      if (idx < 0)
        for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) idx = i;
      if (idx < 0) begin
        idx = m_rr;
        m_rr = (m_rr + 1) % N;
      end
      m_vld[idx] = 1; m_glb[idx] = g; m_vpn[idx] = vpn;
      m_pfn[idx] = pfn; m_prot[idx] = prot; m_dirty[idx] = d;
    end
    @(negedge clk);
    lk = 0; rf = 0; inv = 0; fctx = 0; fall = 0;
    chk(r_valid == exp_v, req, r_valid, exp_v);
    chk(r_hit == exp_h && r_miss == (exp_v && !exp_h), req, {r_hit, r_miss}, {exp_h, exp_v && !exp_h});
    chk(r_pa == exp_pa && r_prot == exp_pr && r_dirty == exp_d, req,
        {r_pa, r_prot, r_dirty}, {exp_pa, exp_pr, exp_d});
  endtask

  task automatic look(input string req, input logic [19:0] vpn, input logic [11:0] off);
    cycle(req, 1, {vpn, off}, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic fill(input string req, input logic [19:0] vpn, input logic [23:0] pfn,
                      input logic [2:0] prot, input bit d, input bit g);
    cycle(req, 0, 0, 1, vpn, pfn, prot, d, g, 0, 0, 0, 0);
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < N; i++) look(req, 20'h100 + 20'(i), 12'((i * 'h1d3) & 'hfff));
    for (int i = 0; i < 3; i++) look(req, 20'h200 + 20'(i), 12'hfff);
    look(req, 20'h300, 12'h000);
    look(req, 20'h301, 12'h801);
    look(req, 20'h400, 12'h7e7);
    look(req, 20'h500, 12'h123);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_vld[i] = 0;
    repeat (3) @(negedge clk);
    chk(!r_valid && !r_hit && !r_miss, "R1", {r_valid, r_hit, r_miss}, 0);
    rst_n = 1'b1;
    look("R1", 20'h100, 12'habc);
    cycle("R2", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R4: fill every free slot in order
    for (int i = 0; i < N; i++)
      fill("R4", 20'h100 + 20'(i), 24'ha0000 + 24'(i * 'h111), 3'(i % 8), i[0], i < 4);
    sweep("R3");
    // R4: re-refill of a cached page overwrites it in place
    fill("R4", 20'h103, 24'h5a5a5a, 3'h6, 1, 1);
    sweep("R4");
    // R5: cache full, round-robin victims 0,1,2
    fill("R5", 20'h200, 24'h111111, 3'h1, 0, 1);
    fill("R5", 20'h201, 24'h222222, 3'h2, 1, 0);
    fill("R5", 20'h202, 24'h333333, 3'h3, 0, 0);
    sweep("R5");
    // R7: drop one page
    cycle("R7", 0, 0, 0, 0, 0, 0, 0, 0, 1, 20'h105, 0, 0);
    sweep("R7");
    // R4/R5: free slot used first, pointer left alone, then victim 3
    fill("R4", 20'h300, 24'h0c0ffe, 3'h5, 1, 1);
    fill("R5", 20'h301, 24'hbeef01, 3'h7, 1, 0);
    sweep("R5");
    // R6: refill beats lookup
    cycle("R6", 1, 32'h104_123, 1, 20'h400, 24'h444444, 3'h4, 0, 0, 0, 0, 0, 0);
    look("R6", 20'h400, 12'h456);
    // R10: context flush drops refill; invalidate blocks lookup
    cycle("R10", 0, 0, 1, 20'h500, 24'h555555, 3'h5, 1, 1, 0, 0, 1, 0);
    look("R10", 20'h500, 12'h000);
    cycle("R10", 1, 32'h200_010, 0, 0, 0, 0, 0, 0, 1, 20'h999, 0, 0);
    // R8: only global entries remain after the context flush above
    sweep("R8");
    // R9: full flush
    cycle("R9", 1, 32'h300_000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    sweep("R9");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule